// File: doc/BRIEF.md
# Branch and Next-PC Unit

This combinational block chooses the address of the next instruction for a 32-bit integer RISC-V core. It receives the address of the current instruction, the two register source values, an immediate offset that has already been sign-extended, and a two-field control select. One field picks the kind of control flow: sequential, conditional branch, PC-relative jump or register-relative jump. The other field picks one of six branch comparisons.

The block drives three outputs. The first is the next PC. The second is a taken flag that tells fetch to redirect. The third is the return address, which a jump writes to its destination register. Both jumps always redirect. A conditional branch redirects only when its comparison holds; otherwise execution falls through to the next word. Fetch, immediate extraction and the register write of the return address belong to neighbouring blocks.

Top module: `nextpc_unit`

## Requirements
- R1: With flow kind 2'b00 (sequential), next_pc equals pc_i + 4 and taken is 0, whatever the register values are.
- R2: Condition codes 3'b000 (equal) and 3'b001 (not equal) compare src_a and src_b for bitwise equality and inequality.
- R3: Condition codes 3'b100 (less than) and 3'b101 (greater or equal) compare src_a against src_b as two's-complement signed numbers.
- R4: Condition codes 3'b110 (less than) and 3'b111 (greater or equal) compare src_a against src_b as unsigned numbers.
- R5: With flow kind 2'b01 (branch) and the selected condition true, taken is 1 and next_pc equals pc_i + offset, with the sum wrapping modulo 2^32.
- R6: With flow kind 2'b01 and the selected condition false, taken is 0 and next_pc equals pc_i + 4.
- R7: With flow kind 2'b10 (PC-relative jump), taken is 1 and next_pc equals pc_i + offset modulo 2^32.
- R8: With flow kind 2'b11 (register-relative jump), taken is 1 and next_pc equals src_a + offset modulo 2^32, with bit 0 cleared.
- R9: ret_addr equals pc_i + 4 modulo 2^32 for every flow kind.
- R10: Condition codes 3'b010 and 3'b011 are reserved. A branch that uses one of them is never taken and falls through to pc_i + 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the current instruction |
| src_a | input | 32 | First register operand; base address for the register-relative jump |
| src_b | input | 32 | Second register operand |
| offset | input | 32 | Sign-extended immediate offset |
| flow_kind | input | 2 | 00 sequential, 01 branch, 10 PC-relative jump, 11 register-relative jump |
| cond_sel | input | 3 | Branch condition code |
| next_pc | output | 32 | Address of the next instruction |
| taken | output | 1 | High when control leaves sequential order |
| ret_addr | output | 32 | Return address, pc_i + 4 |

## Verification
Every condition code, the reserved codes included, is applied to every ordered pair drawn from a set of boundary operands: zero, one, 5, the largest positive value, the most negative value, minus two and minus one. Pairs that straddle the sign bit are the cases where the signed and unsigned orderings disagree. Equal pairs separate the strict comparisons from the greater-or-equal ones. The jump cases use an odd register-plus-offset sum, which shows that bit 0 is cleared, and a PC near the top of the address space, which shows that the target and the return address wrap.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

  localparam int unsigned XLEN       = 32;
  localparam int unsigned INSN_BYTES = 4;

  typedef enum logic [1:0] {
    FLOW_SEQ  = 2'b00,
    FLOW_BR   = 2'b01,
    FLOW_JREL = 2'b10,
    FLOW_JREG = 2'b11
  } flow_e;

  typedef enum logic [2:0] {
    CND_EQ  = 3'b000,
    CND_NE  = 3'b001,
    CND_RS2 = 3'b010,
    CND_RS3 = 3'b011,
    CND_LT  = 3'b100,
    CND_GE  = 3'b101,
    CND_LTU = 3'b110,
    CND_GEU = 3'b111
  } cond_e;

  // Address arithmetic wraps at the word width.
  function automatic logic [XLEN-1:0] addr_add(input logic [XLEN-1:0] base,
                                               input logic [XLEN-1:0] delta);
    return base + delta;
  endfunction

  // Unsigned ordering taken from the borrow out of a widened subtraction.
  function automatic logic borrow_lt(input logic [XLEN-1:0] a,
                                     input logic [XLEN-1:0] b);
    logic [XLEN:0] d;
    d = {1'b0, a} - {1'b0, b};
    return d[XLEN];
  endfunction

endpackage

// File: rtl/nextpc_cmp.sv
module nextpc_cmp
  import nextpc_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   sel,
  output logic         holds
);
  localparam int unsigned MSB = W - 1;

  logic [W:0] diff_w;
  logic       same_w;
  logic       below_u_w;
  logic       below_s_w;
  logic       sign_split_w;

  assign diff_w       = {1'b0, op_a} - {1'b0, op_b};
  assign same_w       = (op_a == op_b);
  assign below_u_w    = diff_w[W];
  assign sign_split_w = op_a[MSB] ^ op_b[MSB];
  // When the signs differ, the negative operand is the smaller one.
  assign below_s_w    = sign_split_w ? op_a[MSB] : below_u_w;

  always_comb begin
    case (sel)
      CND_EQ:  holds = same_w;
      CND_NE:  holds = !same_w;
      CND_LT:  holds = below_s_w;
      CND_GE:  holds = !below_s_w;
      CND_LTU: holds = below_u_w;
      CND_GEU: holds = !below_u_w;
      default: holds = 1'b0;
    endcase
  end

  always_comb begin
    if (same_w) begin
      AST_EQ_NOT_BELOW: assert (!below_u_w && !below_s_w) else $error("equal operands ordered"); // R2
    end
    if (sign_split_w) begin
      AST_SIGN_SPLIT: assert (below_s_w != below_u_w) else $error("signed/unsigned agree across sign"); // R3
    end
    if (sel == CND_RS2 || sel == CND_RS3) begin
      AST_RESERVED_FALSE: assert (!holds) else $error("reserved code holds"); // R10
    end
  end

endmodule

// File: rtl/nextpc_target.sv
module nextpc_target
  import nextpc_pkg::*;
#(
  parameter int unsigned W    = XLEN,
  parameter int unsigned STEP = INSN_BYTES
) (
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] base_reg,
  input  logic [W-1:0] offset,
  input  logic [1:0]   kind,
  input  logic         cond_ok,
  output logic [W-1:0] next_pc,
  output logic         taken,
  output logic [W-1:0] ret_addr
);
  localparam logic [W-1:0] STEP_V   = W'(STEP);
  localparam logic [W-1:0] LSB_MASK = ~W'(1);

  logic [W-1:0] seq_pc_w;
  logic [W-1:0] rel_pc_w;
  logic [W-1:0] reg_pc_w;
  logic         redirect_w;

  assign seq_pc_w = addr_add(pc_i, STEP_V);
  assign rel_pc_w = addr_add(pc_i, offset);
  assign reg_pc_w = addr_add(base_reg, offset) & LSB_MASK;

  always_comb begin
    case (kind)
      FLOW_BR:   redirect_w = cond_ok;
      FLOW_JREL: redirect_w = 1'b1;
      FLOW_JREG: redirect_w = 1'b1;
      default:   redirect_w = 1'b0;
    endcase
  end

  always_comb begin
    if (!redirect_w)            next_pc = seq_pc_w;
    else if (kind == FLOW_JREG) next_pc = reg_pc_w;
    else                        next_pc = rel_pc_w;
  end

  assign taken    = redirect_w;
  assign ret_addr = seq_pc_w;

  always_comb begin
    if (kind == FLOW_SEQ) begin
      AST_SEQ_NOT_TAKEN: assert (!taken) else $error("sequential flow taken"); // R1
    end
    if (!taken) begin
      AST_FALLTHRU_IS_RET: assert (next_pc == ret_addr) else $error("fall-through differs from return"); // R6
    end
    if (kind == FLOW_JREL || kind == FLOW_JREG) begin
      AST_JUMP_TAKEN: assert (taken) else $error("jump not taken"); // R7
    end
    if (kind == FLOW_JREG) begin
      AST_JREG_EVEN: assert (!next_pc[0]) else $error("register jump target odd"); // R8
    end
  end

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int unsigned W    = XLEN,
  parameter int unsigned STEP = INSN_BYTES
) (
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic [W-1:0] offset,
  input  logic [1:0]   flow_kind,
  input  logic [2:0]   cond_sel,
  output logic [W-1:0] next_pc,
  output logic         taken,
  output logic [W-1:0] ret_addr
);
  logic cond_ok_w;

  nextpc_cmp #(.W(W)) u_cmp (
    .op_a  (src_a),
    .op_b  (src_b),
    .sel   (cond_sel),
    .holds (cond_ok_w)
  );

  nextpc_target #(.W(W), .STEP(STEP)) u_tgt (
    .pc_i     (pc_i),
    .base_reg (src_a),
    .offset   (offset),
    .kind     (flow_kind),
    .cond_ok  (cond_ok_w),
    .next_pc  (next_pc),
    .taken    (taken),
    .ret_addr (ret_addr)
  );

  always_comb begin
    if (flow_kind == FLOW_BR && cond_ok_w) begin
      AST_BR_TAKEN: assert (taken) else $error("true branch not taken"); // R5
    end
  end

endmodule

// File: tb/nextpc_unit_test.sv
module nextpc_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_i, src_a, src_b, offset;
  logic [1:0]  flow_kind;
  logic [2:0]  cond_sel;
  logic [31:0] next_pc, ret_addr;
  logic        taken;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  nextpc_unit uut (
    .pc_i(pc_i), .src_a(src_a), .src_b(src_b), .offset(offset),
    .flow_kind(flow_kind), .cond_sel(cond_sel),
    .next_pc(next_pc), .taken(taken), .ret_addr(ret_addr)
  );

  function automatic logic [31:0] pick(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h0000_0005;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'hFFFF_FFFE;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // Reference: signed order via sign-bit flip then unsigned compare.
  function automatic bit ref_cond(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] fa, fb;
    fa = a ^ 32'h8000_0000;
    fb = b ^ 32'h8000_0000;
    case (c)
      3'b000: return a == b;
      3'b001: return a != b;
      3'b100: return fa < fb;
      3'b101: return fa >= fb;
      3'b110: return a < b;
      3'b111: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] exp_pc,
                       input bit exp_tk, input logic [31:0] exp_ret);
    total++;
    if (next_pc !== exp_pc || taken !== exp_tk || ret_addr !== exp_ret) begin
      bad++;
      $display("FAIL %s: pc=%h a=%h b=%h off=%h kind=%b cond=%b got next=%h tk=%b ret=%h exp next=%h tk=%b ret=%h",
               req, pc_i, src_a, src_b, offset, flow_kind, cond_sel,
               next_pc, taken, ret_addr, exp_pc, exp_tk, exp_ret);
    end
  endtask

  task automatic apply(input logic [31:0] p, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] o, input logic [1:0] k, input logic [2:0] c);
    @(negedge clk);
    pc_i = p; src_a = a; src_b = b; offset = o; flow_kind = k; cond_sel = c;
    #1;
  endtask

  function automatic string cond_req(input logic [2:0] c);
    case (c)
      3'b000, 3'b001: return "R2";
      3'b100, 3'b101: return "R3";
      3'b110, 3'b111: return "R4";
      default:        return "R10";
    endcase
  endfunction

  initial begin
    pc_i = '0; src_a = '0; src_b = '0; offset = '0; flow_kind = 2'b00; cond_sel = 3'b000;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Idle state with all-zero inputs: R1, R9
    apply(32'h0, 32'h0, 32'h0, 32'h0, 2'b00, 3'b000);
    check("R1", 32'h4, 1'b0, 32'h4);

    // Sequential ignores operands that would satisfy a branch: R1
    apply(32'h0000_1000, 32'h5, 32'h5, 32'h40, 2'b00, 3'b000);
    check("R1", 32'h0000_1004, 1'b0, 32'h0000_1004);

    // Full condition sweep over boundary operands: R2 R3 R4 R5 R6 R10
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < 7; i++) begin
        for (int j = 0; j < 7; j++) begin
          logic [31:0] p, o;
          bit h;
          p = 32'h0000_2000 + 32'(i * 64 + j * 8);
          o = (c[0]) ? 32'hFFFF_FFF0 : 32'h0000_0100;
          h = ref_cond(3'(c), pick(i), pick(j));
          apply(p, pick(i), pick(j), o, 2'b01, 3'(c));
          check(h ? "R5" : "R6", h ? p + o : p + 32'd4, h, p + 32'd4);
          check(cond_req(3'(c)), h ? p + o : p + 32'd4, h, p + 32'd4);
        end
      end
    end

    // Taken branch wrapping past the top of the space: R5
    apply(32'hFFFF_FFF8, 32'h1, 32'h1, 32'h0000_0010, 2'b01, 3'b000);
    check("R5", 32'h0000_0008, 1'b1, 32'hFFFF_FFFC);

    // PC-relative jump, forward and backward, with wrap: R7
    apply(32'h0000_4000, 32'h0, 32'h0, 32'hFFFF_F000, 2'b10, 3'b010);
    check("R7", 32'h0000_3000, 1'b1, 32'h0000_4004);
    apply(32'hFFFF_FFFC, 32'h0, 32'h0, 32'h0000_0008, 2'b10, 3'b000);
    check("R7", 32'h0000_0004, 1'b1, 32'h0000_0000);

    // Register-relative jump with odd sum, bit 0 cleared: R8
    apply(32'h0000_5000, 32'h0000_8001, 32'h0, 32'h0000_0004, 2'b11, 3'b001);
    check("R8", 32'h0000_8004, 1'b1, 32'h0000_5004);
    apply(32'h0000_5000, 32'hFFFF_FFFF, 32'h0, 32'h0000_0002, 2'b11, 3'b000);
    check("R8", 32'h0000_0000, 1'b1, 32'h0000_5004);
    apply(32'h0000_5000, 32'h0000_0100, 32'h0, 32'hFFFF_FFFF, 2'b11, 3'b000);
    check("R8", 32'h0000_00FE, 1'b1, 32'h0000_5004);

    // Return address wraps at the top for a jump: R9
    apply(32'hFFFF_FFFC, 32'h0000_0100, 32'h0, 32'h0, 2'b11, 3'b000);
    check("R9", 32'h0000_0100, 1'b1, 32'h0000_0000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, got running expected done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule